// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the wall-clock time and the calendar date as packed BCD bytes and advances them once per second. The second is derived from a sub-second strobe (`osc_pulse`) through a prescaler that divides by the parameter `TICK_DIV`. The fields are seconds, minutes, hours, day of week, day of month, month and a two-digit year. The year stands for 2000 through 2099, so every year divisible by four is treated as a leap year.

The hour byte carries its own format. Bit 6 set selects 12-hour mode. In that mode bit 5 set means PM, and bits 4:0 hold a BCD hour from 1 to 12. With bit 6 clear, bits 5:0 hold a BCD hour from 0 to 23. The day of week is a free-running 1..7 counter that steps whenever the date steps, with no link to the date value.

Every field is loaded through a plain one-cycle write port; there is no data stream and no back-pressure. The port addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 control. Only bit 7 of the control byte is kept. It is an active-low run enable: while it is 1 the clock stands still. In a write cycle the strobe is ignored and nothing advances. A write to seconds also clears the prescaler.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), day of week 0x01, day of month 0x01, month 0x01, year 0x00, and `halted` is 1.
- R2: While control bit 7 (address 7) is 1, `halted` is 1 and no field changes, whatever the strobe does; writing 0x00 to address 7 lets the clock run.
- R3: Seconds advance by one on the TICK_DIV-th counted strobe; a write to address 0 clears the prescaler, so the next advance needs a full TICK_DIV strobes after that write.
- R4: Seconds 0x59 roll to 0x00 and carry into minutes; minutes 0x59 roll to 0x00 and carry into the hour.
- R5: In 24-hour mode hour 0x23 rolls to 0x00 and the date advances by one day.
- R6: In 12-hour mode 11 AM (0x51) goes to 12 PM (0x72), 12 goes to 1 with the PM bit unchanged (0x72 to 0x61, 0x52 to 0x41), and 11 PM (0x71) goes to 12 AM (0x52) with a date advance; no other 12-hour step advances the date.
- R7: On each date advance the day of week steps by one, and 0x07 wraps to 0x01, regardless of the date.
- R8: Months 04, 06, 09 and 11 end after day 0x30; all other months except February end after day 0x31; the day then returns to 0x01 and the month advances.
- R9: February ends after day 0x29 when the year value is divisible by four (including 00), and after 0x28 otherwise.
- R10: Month 0x12 rolls to 0x01 with a year increment, and year 0x99 rolls to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_pulse | input | 1 | Sub-second strobe, one cycle per prescaler count |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address (0 s, 1 min, 2 h, 3 weekday, 4 day, 5 month, 6 year, 7 control) |
| wr_data | input | 8 | Write data (packed BCD, or control bit 7) |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour with 12-hour and PM flags |
| wday_o | output | 8 | Day of week 1..7 |
| mday_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00..99, BCD |
| halted | output | 1 | Control bit 7: counting stopped |

## Verification
A wrong carry shows up at the ports only at a rollover. The bench therefore loads each field a second before a boundary and reads all seven bytes one cycle after the deciding tick. A wrong prescaler count is seen as an advance one strobe early or late, so the seconds byte is read just before and just after the TICK_DIV-th strobe. A mishandled PM flag or day length is silent until it hits 11 o'clock, midnight or a month end. Those exact instants are driven in both hour formats, for 30-day months, 31-day months and both kinds of February.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int unsigned FIELD_W = 8;

  typedef enum logic [2:0] {
    ADR_SEC  = 3'd0,
    ADR_MIN  = 3'd1,
    ADR_HOUR = 3'd2,
    ADR_WDAY = 3'd3,
    ADR_MDAY = 3'd4,
    ADR_MON  = 3'd5,
    ADR_YEAR = 3'd6,
    ADR_CTRL = 3'd7
  } rtc_addr_e;

  // Increment a packed two-digit BCD byte (no wrap past 99 handled here).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic run,
  input  logic hold,
  input  logic clear,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          count_en;

  assign count_en = pulse & run & ~hold;
  assign tick     = count_en & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (count_en) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import bcd_rtc_pkg::*;
(
  input  logic [7:0] hour_i,
  output logic [7:0] hour_nxt,
  output logic       day_carry
);
  logic       mode12;
  logic       pm;
  logic [7:0] h12;
  logic [7:0] h24;
  logic [7:0] h12_inc;
  logic [7:0] h24_inc;

  assign mode12  = hour_i[6];
  assign pm      = hour_i[5];
  assign h12     = {3'b000, hour_i[4:0]};
  assign h24     = {2'b00, hour_i[5:0]};
  assign h12_inc = bcd_inc(h12);
  assign h24_inc = bcd_inc(h24);

  always_comb begin
    day_carry = 1'b0;
    if (mode12) begin
      if (h12 == 8'h12) begin
        hour_nxt = {2'b01, pm, 5'h01};
      end else if (h12 == 8'h11) begin
        hour_nxt  = {2'b01, ~pm, 5'h12};
        day_carry = pm;
      end else begin
        hour_nxt = {2'b01, pm, h12_inc[4:0]};
      end
    end else begin
      if (h24 >= 8'h23) begin
        hour_nxt  = 8'h00;
        day_carry = 1'b1;
      end else begin
        hour_nxt = h24_inc;
      end
    end
  end
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
  import bcd_rtc_pkg::*;
(
  input  logic [7:0] mday_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] mday_nxt,
  output logic [7:0] mon_nxt,
  output logic [7:0] year_nxt
);
  logic [7:0] year_bin;
  logic       leap;
  logic [7:0] last_day;

  assign year_bin = bcd_to_bin(year_i);
  assign leap     = (year_bin % 8'd4) == 8'd0;

  always_comb begin
    unique case (mon_i)
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'd30;
      8'h02:                      last_day = leap ? 8'd29 : 8'd28;
      default:                    last_day = 8'd31;
    endcase
  end

  always_comb begin
    mday_nxt = bcd_inc(mday_i);
    mon_nxt  = mon_i;
    year_nxt = year_i;
    if (bcd_to_bin(mday_i) >= last_day) begin
      mday_nxt = 8'h01;
      if (mon_i >= 8'h12) begin
        mon_nxt  = 8'h01;
        year_nxt = (year_i >= 8'h99) ? 8'h00 : bcd_inc(year_i);
      end else begin
        mon_nxt = bcd_inc(mon_i);
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_pulse,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       halted
);
  logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;
  logic       stop_q;
  logic       sec_tick;
  logic       sec_clear;
  logic [7:0] hour_nxt;
  logic       day_carry;
  logic [7:0] mday_nxt, mon_nxt, year_nxt;

  assign sec_clear = wr_en && (rtc_addr_e'(wr_addr) == ADR_SEC);

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (osc_pulse),
    .run   (~stop_q),
    .hold  (wr_en),
    .clear (sec_clear),
    .tick  (sec_tick)
  );

  rtc_hour_step u_hour (
    .hour_i    (hour_q),
    .hour_nxt  (hour_nxt),
    .day_carry (day_carry)
  );

  rtc_date_step u_date (
    .mday_i   (mday_q),
    .mon_i    (mon_q),
    .year_i   (year_q),
    .mday_nxt (mday_nxt),
    .mon_nxt  (mon_nxt),
    .year_nxt (year_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      wday_q <= 8'h01;
      mday_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      stop_q <= 1'b1;
    end else if (wr_en) begin
      unique case (rtc_addr_e'(wr_addr))
        ADR_SEC:  sec_q  <= wr_data;
        ADR_MIN:  min_q  <= wr_data;
        ADR_HOUR: hour_q <= wr_data;
        ADR_WDAY: wday_q <= wr_data;
        ADR_MDAY: mday_q <= wr_data;
        ADR_MON:  mon_q  <= wr_data;
        ADR_YEAR: year_q <= wr_data;
        ADR_CTRL: stop_q <= wr_data[7];
      endcase
    end else if (sec_tick) begin
      if (sec_q >= 8'h59) begin
        sec_q <= 8'h00;
        if (min_q >= 8'h59) begin
          min_q  <= 8'h00;
          hour_q <= hour_nxt;
          if (day_carry) begin
            wday_q <= (wday_q >= 8'h07) ? 8'h01 : bcd_inc(wday_q);
            mday_q <= mday_nxt;
            mon_q  <= mon_nxt;
            year_q <= year_nxt;
          end
        end else begin
          min_q <= bcd_inc(min_q);
        end
      end else begin
        sec_q <= bcd_inc(sec_q);
      end
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign wday_o = wday_q;
  assign mday_o = mday_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
  assign halted = stop_q;
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_pulse,
  input logic       wr_en,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] mday_o,
  input logic       halted
);
  // R2: a stopped clock holds every counted field
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(mday_o)));

  // R3: seconds never move without a strobe or a write
  a_r3_no_step_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_pulse && !wr_en) |=> $stable(sec_o));

  // R4: leaving 59 seconds lands on 00 and moves the minutes
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $past(sec_o) == 8'h59 && sec_o != 8'h59)
      |-> (sec_o == 8'h00 && min_o != $past(min_o)));

  // R6: in 12-hour mode the PM flag flips only on the 11 to 12 step
  a_r6_pm_flip_at_eleven: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $past(hour_o[6]) && hour_o[5] != $past(hour_o[5]))
      |-> ($past(hour_o[4:0]) == 5'h11 && hour_o[4:0] == 5'h12));

  // R7: the weekday steps by one or wraps from 7 to 1
  a_r7_wday_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && wday_o != $past(wday_o))
      |-> ((wday_o == 8'h01 && $past(wday_o) == 8'h07) || (wday_o == $past(wday_o) + 8'h01)));
endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_pulse (osc_pulse),
  .wr_en     (wr_en),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .wday_o    (wday_o),
  .mday_o    (mday_o),
  .halted    (halted)
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_pulse = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
  logic       halted;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_core #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o), .halted(halted)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_pulse = 1'b1;
      @(negedge clk); osc_pulse = 1'b0;
    end
  endtask

  // Date first, then time with seconds last so the prescaler starts at zero.
  task automatic load(input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo,
                      input logic [7:0] yr, input logic [7:0] h, input logic [7:0] m,
                      input logic [7:0] s);
    wr(3'd3, wd); wr(3'd4, md); wr(3'd5, mo); wr(3'd6, yr);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  task automatic t_reset;
    check8("R1 sec", sec_o, 8'h00);
    check8("R1 min", min_o, 8'h00);
    check8("R1 hour", hour_o, 8'h00);
    check8("R1 wday", wday_o, 8'h01);
    check8("R1 mday", mday_o, 8'h01);
    check8("R1 mon", mon_o, 8'h01);
    check8("R1 year", year_o, 8'h00);
    check8("R1 halted", {7'd0, halted}, 8'h01);
  endtask

  task automatic t_stopped;
    strobes(3 * DIV);
    check8("R2 sec held after reset", sec_o, 8'h00);
    wr(3'd7, 8'h00);
    check8("R2 run after enable", {7'd0, halted}, 8'h00);
    load(8'h02, 8'h05, 8'h03, 8'h10, 8'h08, 8'h30, 8'h20);
    wr(3'd7, 8'h80);
    strobes(3 * DIV);
    check8("R2 halted set", {7'd0, halted}, 8'h01);
    check8("R2 sec held", sec_o, 8'h20);
    check8("R2 min held", min_o, 8'h30);
    wr(3'd7, 8'h00);
    strobes(DIV);
    check8("R2 resumes", sec_o, 8'h21);
  endtask

  task automatic t_prescale;
    wr(3'd0, 8'h10);
    strobes(DIV - 1);
    check8("R3 before tick", sec_o, 8'h10);
    strobes(1);
    check8("R3 at tick", sec_o, 8'h11);
    strobes(DIV - 1);
    wr(3'd0, 8'h40);
    strobes(DIV - 1);
    check8("R3 cleared prescaler early", sec_o, 8'h40);
    strobes(1);
    check8("R3 cleared prescaler tick", sec_o, 8'h41);
  endtask

  task automatic t_carry;
    load(8'h01, 8'h10, 8'h03, 8'h10, 8'h05, 8'h10, 8'h59);
    strobes(DIV);
    check8("R4 sec wrap", sec_o, 8'h00);
    check8("R4 min carry", min_o, 8'h11);
    load(8'h01, 8'h10, 8'h03, 8'h10, 8'h12, 8'h59, 8'h59);
    strobes(DIV);
    check8("R4 hour carry", hour_o, 8'h13);
    check8("R4 min wrap", min_o, 8'h00);
    check8("R4 no date change", mday_o, 8'h10);
  endtask

  task automatic t_midnight24;
    load(8'h03, 8'h15, 8'h06, 8'h24, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R5 hour", hour_o, 8'h00);
    check8("R5 mday", mday_o, 8'h16);
    check8("R5 mon", mon_o, 8'h06);
    check8("R7 wday step", wday_o, 8'h04);
  endtask

  task automatic t_twelve;
    load(8'h02, 8'h10, 8'h06, 8'h24, 8'h51, 8'h59, 8'h59);
    strobes(DIV);
    check8("R6 11AM to 12PM", hour_o, 8'h72);
    check8("R6 noon no date step", mday_o, 8'h10);
    load(8'h02, 8'h10, 8'h06, 8'h24, 8'h72, 8'h59, 8'h59);
    strobes(DIV);
    check8("R6 12PM to 1PM", hour_o, 8'h61);
    load(8'h02, 8'h10, 8'h06, 8'h24, 8'h69, 8'h59, 8'h59);
    strobes(DIV);
    check8("R6 9PM to 10PM", hour_o, 8'h70);
    load(8'h02, 8'h10, 8'h06, 8'h24, 8'h71, 8'h59, 8'h59);
    strobes(DIV);
    check8("R6 11PM to 12AM", hour_o, 8'h52);
    check8("R6 midnight date step", mday_o, 8'h11);
    check8("R6 midnight wday", wday_o, 8'h03);
    load(8'h02, 8'h10, 8'h06, 8'h24, 8'h52, 8'h59, 8'h59);
    strobes(DIV);
    check8("R6 12AM to 1AM", hour_o, 8'h41);
    check8("R6 1AM no date step", mday_o, 8'h10);
  endtask

  task automatic t_weekday_wrap;
    load(8'h07, 8'h20, 8'h08, 8'h24, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R7 wday wrap", wday_o, 8'h01);
    check8("R7 date independent", mday_o, 8'h21);
  endtask

  task automatic t_months;
    load(8'h01, 8'h30, 8'h04, 8'h24, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R8 30-day mday", mday_o, 8'h01);
    check8("R8 30-day mon", mon_o, 8'h05);
    load(8'h01, 8'h30, 8'h05, 8'h24, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R8 31-day continues", mday_o, 8'h31);
    load(8'h01, 8'h31, 8'h01, 8'h24, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R8 31-day mday", mday_o, 8'h01);
    check8("R8 31-day mon", mon_o, 8'h02);
    load(8'h01, 8'h30, 8'h11, 8'h24, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R8 november end", mon_o, 8'h12);
  endtask

  task automatic t_february;
    load(8'h01, 8'h28, 8'h02, 8'h01, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R9 common year mday", mday_o, 8'h01);
    check8("R9 common year mon", mon_o, 8'h03);
    load(8'h01, 8'h28, 8'h02, 8'h24, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R9 leap year day 29", mday_o, 8'h29);
    check8("R9 leap year mon", mon_o, 8'h02);
    load(8'h01, 8'h29, 8'h02, 8'h00, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R9 year 00 leap end", mday_o, 8'h01);
    check8("R9 year 00 mon", mon_o, 8'h03);
  endtask

  task automatic t_year;
    load(8'h05, 8'h31, 8'h12, 8'h19, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R10 month wrap", mon_o, 8'h01);
    check8("R10 year bcd inc", year_o, 8'h20);
    load(8'h05, 8'h31, 8'h12, 8'h99, 8'h23, 8'h59, 8'h59);
    strobes(DIV);
    check8("R10 year wrap", year_o, 8'h00);
    check8("R10 mday", mday_o, 8'h01);
    check8("R10 mon", mon_o, 8'h01);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_prescale();
    t_carry();
    t_midnight24();
    t_twelve();
    t_weekday_wrap();
    t_months();
    t_february();
    t_year();
    finish_run();
  end
endmodule